// File: doc/BRIEF.md
# Multi-Register Stack Transfer Sequencer

This control sub-unit executes the save-many and restore-many stack instructions of a 32-bit load/store processor. When the decoder raises `start`, it captures a 16-bit selection mask, the index of the register that serves as stack pointer, and the direction. It then visits each selected register in turn. For each one it issues a single long-word memory access, moves the pointer by four bytes, and either reads the register file (save) or writes it (restore). When the whole set has moved, the adjusted pointer is written back to the stack register and `done` is pulsed.

Each step takes two cycles, an address cycle and a transfer cycle, around a fixed overhead of three cycles. A step waits for the memory acknowledge, so a slow memory stretches the instruction without changing its result. Saves run from low register index to high and restores from high to low. A save followed by a restore with the same mask therefore puts every register back.

Top module: `stkx_seq`

## Requirements
- R1: With an acknowledge in the same cycle as every request, an instruction that moves N registers lasts 3 + 2N cycles, counted from the cycle in which `start` is sampled in idle up to and including the single cycle in which `done` is high. Exactly N memory transfers take place.
- R2: When `pop_op` = 0 (save), the registers whose bit i of `reg_mask` is 1 (bit i selects register i) are handled in ascending index order. For each one the pointer is first lowered by 4, and then the register's value is written to the new pointer address.
- R3: When `pop_op` = 1 (restore), the selected registers are handled in descending index order. For each one the word at the current pointer address is read into the register, and then the pointer is raised by 4.
- R4: In the final cycle (`done` high) the stack register named by `sp_sel` is written with its starting value minus 4N for a save, or plus 4N for a restore.
- R5: An all-zero mask finishes in 3 cycles, makes no memory request, and leaves the stack register unchanged.
- R6: A save whose mask includes the stack register stores that register's value from before the instruction.
- R7: A restore whose mask includes the stack register leaves the stack register holding the final adjusted pointer, not the word read from memory.
- R8: A request stays high with the same address, direction and write data until it is acknowledged. Wait cycles lengthen the instruction by exactly their number and do not change the result.
- R9: Every memory access is a 32-bit word access at an address whose two low bits are zero.
- R10: `start` and the instruction inputs are ignored from the cycle after acceptance until the sequencer has returned to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an instruction (sampled in idle only) |
| pop_op | input | 1 | 0 = save to stack, 1 = restore from stack |
| reg_mask | input | 16 | Register selection, bit i selects register i |
| sp_sel | input | 4 | Index of the stack-pointer register |
| rf_raddr | output | 4 | Register file read address |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write address |
| rf_wdata | output | 32 | Register file write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ack | input | 1 | Memory acknowledge, transfer completes on the edge where it is high |
| done | output | 1 | One-cycle completion pulse |

## Verification
In the address cycle of a save, the pointer decrement and the register file read of the data word happen together. When the stack register is itself in the mask, that single cycle both lowers the pointer and reads the stack register as data. The bench provokes this with save masks that include the `sp_sel` register. It judges the result by checking that memory holds the pre-instruction pointer value, while the register written back in the final cycle holds the lowered one. The mirror case, a restore whose mask includes the stack register, is judged by the final register value, which must be the pointer and not the word read from memory.

// File: rtl/stkx_pkg.sv
`timescale 1ns/1ps
package stkx_pkg;

  // Sequencer phases: accept, settle, per-register address/transfer, write back.
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PREP = 3'd1,
    ST_ADDR = 3'd2,
    ST_XFER = 3'd3,
    ST_DONE = 3'd4
  } stkx_state_e;

  typedef enum logic {
    DIR_SAVE    = 1'b0,
    DIR_RESTORE = 1'b1
  } stkx_dir_e;

endpackage

// File: rtl/stkx_rstsync.sv
`timescale 1ns/1ps
module stkx_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/stkx_pick.sv
`timescale 1ns/1ps
// Finds the lowest and highest set bit of the pending mask.
module stkx_pick #(
  parameter int unsigned NREG = 16,
  localparam int unsigned IDXW = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask,
  output logic [IDXW-1:0] lo_idx,
  output logic [IDXW-1:0] hi_idx,
  output logic            any
);

  always_comb begin
    lo_idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask[i]) lo_idx = IDXW'(i);
    end
  end

  always_comb begin
    hi_idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (mask[i]) hi_idx = IDXW'(i);
    end
  end

  assign any = |mask;

endmodule

// File: rtl/stkx_ptr.sv
`timescale 1ns/1ps
// Working copy of the stack pointer, stepping by one word.
module stkx_ptr #(
  parameter int unsigned DW = 32,
  localparam int unsigned STEP = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [DW-1:0] load_val,
  input  logic          dec_en,
  input  logic          inc_en,
  output logic [DW-1:0] ptr
);

  logic [DW-1:0] ptr_q;
  logic [DW-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load_en)     ptr_d = load_val;
    else if (dec_en) ptr_d = ptr_q - DW'(STEP);
    else if (inc_en) ptr_d = ptr_q + DW'(STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/stkx_ctrl.sv
`timescale 1ns/1ps
module stkx_ctrl
  import stkx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic mask_nz,
  input  logic more_left,
  input  logic mem_ack,
  output logic st_idle,
  output logic st_prep,
  output logic st_addr,
  output logic st_xfer,
  output logic st_done
);

  stkx_state_e state_q;
  stkx_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_PREP;
      ST_PREP: state_d = mask_nz ? ST_ADDR : ST_DONE;
      ST_ADDR: state_d = ST_XFER;
      ST_XFER: if (mem_ack) state_d = more_left ? ST_ADDR : ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign st_idle = (state_q == ST_IDLE);
  assign st_prep = (state_q == ST_PREP);
  assign st_addr = (state_q == ST_ADDR);
  assign st_xfer = (state_q == ST_XFER);
  assign st_done = (state_q == ST_DONE);

endmodule

// File: rtl/stkx_seq.sv
`timescale 1ns/1ps
module stkx_seq
  import stkx_pkg::*;
#(
  parameter int unsigned NREG = 16,
  parameter int unsigned DW   = 32,
  localparam int unsigned IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            pop_op,
  input  logic [NREG-1:0] reg_mask,
  input  logic [IDXW-1:0] sp_sel,
  output logic [IDXW-1:0] rf_raddr,
  input  logic [DW-1:0]   rf_rdata,
  output logic            rf_we,
  output logic [IDXW-1:0] rf_waddr,
  output logic [DW-1:0]   rf_wdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ack,
  output logic            done
);

  logic rst_i_n;
  logic st_idle, st_prep, st_addr, st_xfer, st_done;

  stkx_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // Captured instruction fields
  logic [NREG-1:0] mask_q, mask_d;
  stkx_dir_e       dir_q;
  logic [IDXW-1:0] spi_q;
  logic [IDXW-1:0] cur_q;
  logic [DW-1:0]   wdat_q;

  logic            accept;
  logic            step_ok;
  logic [IDXW-1:0] lo_idx, hi_idx, pick_idx;
  logic            mask_nz;
  logic [NREG-1:0] cur_bit;
  logic [NREG-1:0] mask_rem;
  logic [DW-1:0]   ptr;

  assign accept  = st_idle & start;
  assign step_ok = st_xfer & mem_ack;

  stkx_pick #(.NREG(NREG)) u_pick (
    .mask   (mask_q),
    .lo_idx (lo_idx),
    .hi_idx (hi_idx),
    .any    (mask_nz)
  );

  // Saves walk upward, restores walk downward.
  assign pick_idx = (dir_q == DIR_RESTORE) ? hi_idx : lo_idx;
  assign cur_bit  = {{(NREG-1){1'b0}}, 1'b1} << cur_q;
  assign mask_rem = mask_q & ~cur_bit;

  stkx_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .start     (start),
    .mask_nz   (mask_nz),
    .more_left (|mask_rem),
    .mem_ack   (mem_ack),
    .st_idle   (st_idle),
    .st_prep   (st_prep),
    .st_addr   (st_addr),
    .st_xfer   (st_xfer),
    .st_done   (st_done)
  );

  stkx_ptr #(.DW(DW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load_en  (accept),
    .load_val (rf_rdata),
    .dec_en   (st_addr & (dir_q == DIR_SAVE)),
    .inc_en   (step_ok & (dir_q == DIR_RESTORE)),
    .ptr      (ptr)
  );

  // Mask bookkeeping: load on accept, retire one bit per completed step.
  always_comb begin
    mask_d = mask_q;
    if (accept)       mask_d = reg_mask;
    else if (step_ok) mask_d = mask_rem;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) mask_q <= '0;
    else          mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      dir_q <= DIR_SAVE;
      spi_q <= '0;
    end else if (accept) begin
      dir_q <= stkx_dir_e'(pop_op);
      spi_q <= sp_sel;
    end
  end

  // Address cycle: latch the register index and, for a save, its value.
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cur_q  <= '0;
      wdat_q <= '0;
    end else if (st_addr) begin
      cur_q  <= pick_idx;
      wdat_q <= rf_rdata;
    end
  end

  assign rf_raddr = st_idle ? sp_sel : pick_idx;

  assign mem_req   = st_xfer;
  assign mem_we    = (dir_q == DIR_SAVE);
  assign mem_addr  = ptr;
  assign mem_wdata = wdat_q;

  assign rf_we    = (step_ok & (dir_q == DIR_RESTORE)) | st_done;
  assign rf_waddr = st_done ? spi_q : cur_q;
  assign rf_wdata = st_done ? ptr : mem_rdata;

  assign done = st_done;

endmodule

// File: rtl/stkx_chk.sv
`timescale 1ns/1ps
module stkx_chk #(
  parameter int unsigned NREG = 16,
  parameter int unsigned DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            idle,
  input logic [NREG-1:0] reg_mask,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ack,
  input logic [DW-1:0]   mem_addr,
  input logic [DW-1:0]   mem_wdata,
  input logic            rf_we,
  input logic            done
);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R9
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  sp_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rf_we);

  // R3
  restore_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_we) |-> rf_we);

  // R5
  empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start && (reg_mask == '0)) |=> (!mem_req && !done) ##1 (!mem_req && done));

  // R10
  busy_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start) |=> !idle);

endmodule

bind stkx_seq stkx_chk #(.NREG(NREG), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .idle      (st_idle),
  .reg_mask  (reg_mask),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .rf_we     (rf_we),
  .done      (done)
);

// File: tb/stkx_seq_tb.sv
`timescale 1ns/1ps
module stkx_seq_tb;

  localparam int NV = 9;
  localparam logic [31:0] BASE = 32'h0000_0200;
  // {hold_start, waits[1:0], pop, sp[3:0], mask[15:0]}
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 2'd0, 1'b0, 4'd15, 16'h002A},
    {1'b0, 2'd0, 1'b1, 4'd15, 16'h002A},
    {1'b0, 2'd0, 1'b0, 4'd13, 16'h0000},
    {1'b0, 2'd0, 1'b1, 4'd2,  16'h0000},
    {1'b0, 2'd0, 1'b0, 4'd4,  16'h0090},
    {1'b0, 2'd0, 1'b1, 4'd4,  16'h0091},
    {1'b0, 2'd2, 1'b0, 4'd15, 16'hFFFF},
    {1'b1, 2'd1, 1'b1, 4'd0,  16'h8001},
    {1'b1, 2'd0, 1'b0, 4'd7,  16'h8421}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        pop_op;
  logic [15:0] reg_mask;
  logic [3:0]  sp_sel;
  logic [3:0]  rf_raddr;
  logic [31:0] rf_rdata;
  logic        rf_we;
  logic [3:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        mem_ack;
  logic        done;

  logic [31:0] rf  [16];
  logic [31:0] mem [256];
  logic [1:0]  waitn;
  logic [1:0]  wcnt;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  stkx_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pop_op(pop_op),
    .reg_mask(reg_mask), .sp_sel(sp_sel),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .done(done)
  );

  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = mem[mem_addr[9:2]];
  assign mem_ack   = mem_req && (wcnt >= waitn);

  always @(posedge clk) begin
    if (!mem_req || mem_ack) wcnt <= 2'd0;
    else                     wcnt <= wcnt + 2'd1;
    if (mem_req && mem_ack && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (rf_we) rf[rf_waddr] <= rf_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_vec(input int k);
    logic [23:0] v;
    logic        hold;
    logic        op;
    logic [3:0]  sp;
    logic [15:0] m;
    logic [1:0]  w;
    int          n, cyc, xf, misal;
    logic [31:0] p;
    logic [31:0] exp_rf [16];
    logic [31:0] exp_mem [256];
    string       rtag;
    string       ctag;
    logic [31:0] bad_rf, bad_mem;

    v = VEC[k];
    hold = v[23]; w = v[22:21]; op = v[20]; sp = v[19:16]; m = v[15:0];
    n = $countones(m);
    @(negedge clk);
    waitn = w;
    for (int i = 0; i < 16; i++) rf[i] = 32'hA000_0000 | (k << 8) | i;
    rf[sp] = op ? (BASE - 32'(4 * n)) : BASE;
    for (int i = 0; i < 16; i++) exp_rf[i] = rf[i];
    for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
    p = rf[sp];
    if (!op) begin
      for (int i = 0; i < 16; i++)
        if (m[i]) begin p = p - 32'd4; exp_mem[p[9:2]] = exp_rf[i]; end
    end else begin
      for (int i = 15; i >= 0; i--)
        if (m[i]) begin exp_rf[i] = mem[p[9:2]]; p = p + 32'd4; end
    end
    exp_rf[sp] = p;

    start = 1'b1; pop_op = op; reg_mask = m; sp_sel = sp;
    cyc = 1; xf = 0; misal = 0;
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      cyc++;
      if (mem_req && mem_ack) xf++;
      if (mem_req && mem_addr[1:0] != 2'b00) misal++;
      if (done) begin start = 1'b0; break; end
      if (hold) begin
        start = 1'b1; pop_op = ~op; reg_mask = ~m; sp_sel = sp + 4'd1;
      end else begin
        start = 1'b0;
      end
    end

    rtag = op ? "R3" : "R2";
    if (m[sp]) rtag = op ? "R7" : "R6";
    if (hold)  rtag = "R10";
    ctag = (w != 0) ? "R8" : ((n == 0) ? "R5" : "R1");
    chk(ctag, 32'(cyc), 32'(3 + (2 + w) * n));
    chk((n == 0) ? "R5" : "R1", 32'(xf), 32'(n));
    chk("R9", 32'(misal), 32'd0);

    @(negedge clk);
    chk("R1", {31'd0, done}, 32'd0);
    chk((n == 0) ? "R5" : "R4", rf[sp], exp_rf[sp]);
    bad_rf = 0;
    for (int i = 0; i < 16; i++) if (rf[i] !== exp_rf[i]) bad_rf++;
    chk(rtag, bad_rf, 32'd0);
    bad_mem = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad_mem++;
    chk(rtag, bad_mem, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1: watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; pop_op = 1'b0; reg_mask = '0; sp_sel = '0;
    waitn = 2'd0; wcnt = 2'd0;
    for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 | i;
    for (int i = 0; i < 16; i++) rf[i] = '0;
    repeat (3) @(negedge clk);
    // Reset state: nothing requested, nothing written, not done (R1, R5)
    chk("R1", {31'd0, done}, 32'd0);
    chk("R5", {31'd0, mem_req}, 32'd0);
    chk("R4", {31'd0, rf_we}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Vector walk: save/restore round trip, empty masks, stack register
    // inside the mask, wait states and start held high while busy.
    for (int k = 0; k < NV; k++) run_vec(k);

    // Directed: start held low after a run leaves the block idle (R10)
    repeat (3) @(negedge clk);
    chk("R10", {31'd0, mem_req}, 32'd0);
    chk("R10", {31'd0, done}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule